// File: doc/BRIEF.md
# Register-Cached Operand Stack

This block is the operand stack of a stack-oriented processor core. The two topmost entries sit in flip-flops: the top in register A, exposed as `tos_o`, and the one below it in register B, exposed as `nos_o`. Everything deeper lives in a RAM with one write port and one combinational read port. Each clock the core's decoder presents one micro-operation: a binary ALU step, a push of an externally supplied word, a push of a local variable, a pop to the store output, or a no-op. The block finishes that operation in the same cycle, including any spill of B into the RAM and any fill of B from it. No write-back stage and no bypass network are needed.

The stack pointer `sp_o` holds the RAM address of the third stack entry. A push spills the old B to address sp+1. A pop or ALU step refills B from address sp. Local variables are read at the frame-pointer input plus an offset. Over- and underflow are not detected: the pointer wraps modulo the RAM depth, which must be a power of two.

Top module: `stk_cache_top`

## Requirements
- R1: While reset is applied, and after it until the first operation, `tos_o` and `nos_o` are 0, `sp_o` equals parameter SP_INIT (default 0), and `st_valid_o` is 0.
- R2: Operation code 1 (ALU) puts f(A,B) into A one clock later. The function is chosen by `fn_i`: 0 gives A+B, 1 gives A−B, 2 gives A AND B, 3 gives A XOR B, all modulo 2^DW.
- R3: On an ALU operation, B takes the RAM word at address sp, sp decrements by one, and the RAM is not written.
- R4: Operation code 2 (push) loads `din_i` into A, moves the old A into B, writes the old B to RAM address sp+1, and increments sp.
- R5: Operation code 3 (local load) loads into A the RAM word at address `vp_i`+`off_i` (modulo depth), moves the old A into B, writes the old B to RAM address sp+1, and increments sp.
- R6: When a local load reads the same address that its own spill writes (vp+off = sp+1), A receives the content the RAM held before that cycle's write.
- R7: Operation code 4 (pop) presents the old A on `st_data_o`, with `st_valid_o` high for exactly the following cycle. It moves B into A, loads B from RAM address sp, and decrements sp.
- R8: Operation code 0, and any unlisted code (5 to 7), changes none of A, B, sp or the RAM, and drives `st_valid_o` low. `st_data_o` keeps its value whenever no pop occurs.
- R9: The stack pointer wraps modulo DEPTH in both directions (DEPTH−1+1 gives 0, and 0−1 gives DEPTH−1), and the RAM addresses derived from it wrap the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Micro-operation code |
| fn_i | input | 2 | ALU function select |
| din_i | input | DW | Word pushed by operation 2 |
| vp_i | input | AW | Local-variable frame pointer |
| off_i | input | OFFW | Local-variable offset |
| tos_o | output | DW | Register A, top of stack |
| nos_o | output | DW | Register B, second entry |
| sp_o | output | AW | Stack pointer (RAM address of the third entry) |
| st_data_o | output | DW | Popped word |
| st_valid_o | output | 1 | High for one cycle after a pop |

## Verification
A local load performs a RAM read and a RAM spill write in the same cycle. Those two accesses can hit the same word when the frame pointer plus the offset equals sp+1. The bench sets up this collision on purpose by choosing `vp_i` from its model's stack pointer, and it requires A to receive the value stored before that cycle's write. A scoreboard fed by a reference stack model then judges the following pops, which must return the spilled value intact. Pointer wrap in both directions is reached by pushing past the RAM depth and then popping through address zero.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ALU  = 3'd1,
    OP_PUSH = 3'd2,
    OP_LVAR = 3'd3,
    OP_POP  = 3'd4
  } stk_op_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    ASRC_ALU = 2'd0,
    ASRC_DIN = 2'd1,
    ASRC_RAM = 2'd2,
    ASRC_NOS = 2'd3
  } a_src_e;

  typedef struct packed {
    logic   a_we;      // register A loads
    a_src_e a_src;
    logic   b_we;      // register B loads
    logic   b_from_a;  // 1: old A, 0: RAM read data
    logic   ram_we;    // spill old B to sp+1
    logic   rd_local;  // read address is vp+off instead of sp
    logic   sp_inc;
    logic   sp_dec;
    logic   st_fire;
  } stk_ctl_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic [2:0] op_i,
  output stk_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    ctl_o.a_src = ASRC_ALU;
    case (op_i)
      OP_ALU: begin
        ctl_o.a_we   = 1'b1;
        ctl_o.a_src  = ASRC_ALU;
        ctl_o.b_we   = 1'b1;
        ctl_o.sp_dec = 1'b1;
      end
      OP_PUSH: begin
        ctl_o.a_we     = 1'b1;
        ctl_o.a_src    = ASRC_DIN;
        ctl_o.b_we     = 1'b1;
        ctl_o.b_from_a = 1'b1;
        ctl_o.ram_we   = 1'b1;
        ctl_o.sp_inc   = 1'b1;
      end
      OP_LVAR: begin
        ctl_o.a_we     = 1'b1;
        ctl_o.a_src    = ASRC_RAM;
        ctl_o.b_we     = 1'b1;
        ctl_o.b_from_a = 1'b1;
        ctl_o.ram_we   = 1'b1;
        ctl_o.rd_local = 1'b1;
        ctl_o.sp_inc   = 1'b1;
      end
      OP_POP: begin
        ctl_o.a_we    = 1'b1;
        ctl_o.a_src   = ASRC_NOS;
        ctl_o.b_we    = 1'b1;
        ctl_o.sp_dec  = 1'b1;
        ctl_o.st_fire = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);

  always_comb begin
    case (fn_i)
      FN_ADD:  y_o = a_i + b_i;
      FN_SUB:  y_o = a_i - b_i;
      FN_AND:  y_o = a_i & b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read sees the content before this cycle's write
  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/stk_cache_top.sv
module stk_cache_top
  import stk_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH   = 256,
  parameter int OFFW    = 4,
  parameter int SP_INIT = 0,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [1:0]      fn_i,
  input  logic [DW-1:0]   din_i,
  input  logic [AW-1:0]   vp_i,
  input  logic [OFFW-1:0] off_i,
  output logic [DW-1:0]   tos_o,
  output logic [DW-1:0]   nos_o,
  output logic [AW-1:0]   sp_o,
  output logic [DW-1:0]   st_data_o,
  output logic            st_valid_o
);

  localparam logic [AW-1:0] SP_RST = AW'(SP_INIT);
  localparam logic [AW-1:0] ONE    = AW'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  stk_ctl_t ctl;
  stk_ctrl u_ctrl (.op_i(op_i), .ctl_o(ctl));

  logic [DW-1:0] tos_q, nos_q, st_data_q;
  logic [AW-1:0] sp_q;
  logic          st_valid_q;

  logic [DW-1:0] alu_y;
  stk_alu #(.DW(DW)) u_alu (.fn_i(fn_i), .a_i(tos_q), .b_i(nos_q), .y_o(alu_y));

  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data;
  assign rd_addr = ctl.rd_local ? (vp_i + AW'(off_i)) : sp_q;
  assign wr_addr = sp_q + ONE;

  stk_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk     (clk),
    .we_i    (ctl.ram_we),
    .waddr_i (wr_addr),
    .wdata_i (nos_q),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  // next-state
  logic [DW-1:0] tos_d, nos_d;
  logic [AW-1:0] sp_d;
  logic          tos_en, nos_en, sp_en, st_en;

  always_comb begin
    case (ctl.a_src)
      ASRC_ALU: tos_d = alu_y;
      ASRC_DIN: tos_d = din_i;
      ASRC_RAM: tos_d = rd_data;
      default:  tos_d = nos_q;
    endcase
    nos_d  = ctl.b_from_a ? tos_q : rd_data;
    sp_d   = ctl.sp_inc ? (sp_q + ONE) : (sp_q - ONE);
    tos_en = ctl.a_we;
    nos_en = ctl.b_we;
    sp_en  = ctl.sp_inc | ctl.sp_dec;
    st_en  = ctl.st_fire;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tos_q      <= '0;
      nos_q      <= '0;
      sp_q       <= SP_RST;
      st_valid_q <= 1'b0;
    end else begin
      if (tos_en) tos_q <= tos_d;
      if (nos_en) nos_q <= nos_d;
      if (sp_en)  sp_q  <= sp_d;
      st_valid_q <= st_en;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     st_data_q <= '0;
    else if (st_en) st_data_q <= tos_q;
  end

  assign tos_o      = tos_q;
  assign nos_o      = nos_q;
  assign sp_o       = sp_q;
  assign st_data_o  = st_data_q;
  assign st_valid_o = st_valid_q;

  // assertions
  logic is_alu, is_push, is_lvar, is_pop, is_idle;
  assign is_alu  = (op_i == 3'(OP_ALU));
  assign is_push = (op_i == 3'(OP_PUSH));
  assign is_lvar = (op_i == 3'(OP_LVAR));
  assign is_pop  = (op_i == 3'(OP_POP));
  assign is_idle = !(is_alu || is_push || is_lvar || is_pop);

  assert_alu_fill_R3: assert property (@(posedge clk) disable iff (!rst_q)
    is_alu |=> (nos_q == $past(rd_data)) && (sp_q == $past(sp_q) - ONE));

  assert_push_shift_R4: assert property (@(posedge clk) disable iff (!rst_q)
    is_push |=> (tos_q == $past(din_i)) && (nos_q == $past(tos_q))
                && (sp_q == $past(sp_q) + ONE));

  assert_local_load_R5: assert property (@(posedge clk) disable iff (!rst_q)
    is_lvar |=> (tos_q == $past(rd_data)) && (nos_q == $past(tos_q)));

  assert_pop_out_R7: assert property (@(posedge clk) disable iff (!rst_q)
    is_pop |=> st_valid_o && (st_data_o == $past(tos_q)) && (tos_q == $past(nos_q)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    is_idle |=> $stable(tos_q) && $stable(nos_q) && $stable(sp_q) && !st_valid_o);

  assert_idle_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_q)
    is_idle |-> !ctl.ram_we);

endmodule

// File: tb/tb_stk_cache_top.sv
module tb_stk_cache_top;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_i = '0;
  logic [1:0]    fn_i = '0;
  logic [DW-1:0] din_i = '0;
  logic [AW-1:0] vp_i = '0;
  logic [3:0]    off_i = '0;
  logic [DW-1:0] tos_o, nos_o, st_data_o;
  logic [AW-1:0] sp_o;
  logic          st_valid_o;

  stk_cache_top dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .fn_i(fn_i), .din_i(din_i),
    .vp_i(vp_i), .off_i(off_i), .tos_o(tos_o), .nos_o(nos_o), .sp_o(sp_o),
    .st_data_o(st_data_o), .st_valid_o(st_valid_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [DW-1:0] tos, nos, std;
    logic [AW-1:0] sp;
    logic          stv;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_a = '0, m_b = '0, m_std = '0;
  logic [AW-1:0] m_sp = '0;
  logic          m_stv = 1'b0;
  logic [DW-1:0] mram [DEPTH];

  task automatic drive(input logic [2:0] op, input logic [1:0] fn,
                       input logic [DW-1:0] din, input logic [AW-1:0] vp,
                       input logic [3:0] off);
    exp_t e;
    logic [DW-1:0] rd, r;
    logic [AW-1:0] la, old_sp;
    string t;
    @(negedge clk);
    op_i = op; fn_i = fn; din_i = din; vp_i = vp; off_i = off;
    old_sp = m_sp;
    la = vp + AW'(off);
    t = "R8";
    m_stv = 1'b0;
    case (op)
      3'd1: begin
        case (fn)
          2'd0: r = m_a + m_b;
          2'd1: r = m_a - m_b;
          2'd2: r = m_a & m_b;
          default: r = m_a ^ m_b;
        endcase
        m_a = r; m_b = mram[m_sp]; m_sp = m_sp - 1'b1; t = "R2 R3";
      end
      3'd2: begin
        mram[m_sp + 1'b1] = m_b; m_b = m_a; m_a = din; m_sp = m_sp + 1'b1; t = "R4";
      end
      3'd3: begin
        rd = mram[la];
        if (la == m_sp + 1'b1) t = "R6"; else t = "R5";
        mram[m_sp + 1'b1] = m_b; m_b = m_a; m_a = rd; m_sp = m_sp + 1'b1;
      end
      3'd4: begin
        m_std = m_a; m_stv = 1'b1; m_a = m_b; m_b = mram[m_sp];
        m_sp = m_sp - 1'b1; t = "R7";
      end
      default: ;
    endcase
    if (t != "R6" && ((old_sp == AW'(DEPTH-1) && m_sp == '0) ||
                      (old_sp == '0 && m_sp == AW'(DEPTH-1))))
      t = "R9";
    e.tos = m_a; e.nos = m_b; e.sp = m_sp; e.stv = m_stv; e.std = m_std; e.tag = t;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() != 0) begin
      e = q.pop_front();
      total++;
      if (tos_o !== e.tos || nos_o !== e.nos || sp_o !== e.sp || st_valid_o !== e.stv ||
          (e.stv && st_data_o !== e.std)) begin
        fails++;
        $display("FAIL %s: tos=%h nos=%h sp=%0d stv=%b std=%h expected tos=%h nos=%h sp=%0d stv=%b std=%h",
                 e.tag, tos_o, nos_o, sp_o, st_valid_o, st_data_o,
                 e.tos, e.nos, e.sp, e.stv, e.std);
      end
    end
  end

  task automatic check_reset(input string when);
    total++;
    if (tos_o !== '0 || nos_o !== '0 || sp_o !== '0 || st_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 (%s): tos=%h nos=%h sp=%0d stv=%b expected 0 0 0 0",
               when, tos_o, nos_o, sp_o, st_valid_o);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset("after release");

    // fill the whole RAM; the pointer wraps upward (R9)
    for (int i = 0; i < DEPTH + 6; i++)
      drive(3'd2, 2'd0, $urandom, '0, '0);

    // every ALU function (R2)
    for (int f = 0; f < 4; f++) begin
      drive(3'd2, 2'd0, $urandom, '0, '0);
      drive(3'd1, 2'(f), '0, '0, '0);
    end

    // local load colliding with its own spill (R6), then pop the spilled word back
    for (int k = 0; k < 4; k++) begin
      drive(3'd3, 2'd0, '0, m_sp + 1'b1 - AW'(4'(k * 3)), 4'(k * 3));
      drive(3'd4, 2'd0, '0, '0, '0);
      drive(3'd4, 2'd0, '0, '0, '0);
    end

    // ordinary local load (R5), idle codes (R8)
    drive(3'd3, 2'd0, '0, m_sp - AW'(5), 4'd2);
    drive(3'd0, 2'd0, 32'hdead_beef, '0, '0);
    drive(3'd6, 2'd1, 32'h1234_5678, '0, '0);
    drive(3'd7, 2'd0, '0, '0, '0);

    // pop through address zero (R9 downward)
    for (int i = 0; i < 12; i++) drive(3'd4, 2'd0, '0, '0, '0);

    // mixed random sequence
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op > 3'd4) op = 3'd0;
      drive(op, 2'($urandom), $urandom, AW'($urandom), 4'($urandom));
    end

    drive(3'd0, 2'd0, '0, '0, '0);
    drive(3'd0, 2'd0, '0, '0, '0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule